// File: doc/BRIEF.md
# Three-Dimensional Linked-Descriptor DMA Address Generator

This block drives the address side of one DMA channel. Software fills a small descriptor store, where every slot is eight 32-bit words. The channel is bound to one slot, called the active slot. When a trigger arrives, the block walks a three-level transfer made of elements, arrays and frames. For each array it hands one source/destination address pair and a byte count to a downstream data mover. The handoff uses a valid/ready handshake.

Two synchronisation modes are supported. In per-array mode each trigger moves one array. In per-frame mode each trigger moves a whole frame of arrays. Each address side can either step through memory or stay fixed on a FIFO port.

When a trigger's work is done, the block pulses a completion event. The event carries the descriptor's completion code and optional interrupt and chaining flags. When the whole descriptor is exhausted, the channel takes a fresh descriptor from the slot named in its link field, unless the descriptor is marked static or the link is null.

Top module: `dma3d_agen`

## Requirements
- R1: While reset is held and after it is released, `req_valid`, `evt_done`, `evt_final`, `evt_irq` and `evt_chain` are 0 and `stat_code` is 0.
- R2: Word w of slot s is written at `wr_addr = s*8 + w`. The words are, in order:
  - word 0: options.
  - word 1: source address.
  - word 2: counts, with the byte count per array in bits 15:0 and the arrays per frame in bits 31:16.
  - word 3: destination address.
  - word 4: array step, signed, with source in bits 15:0 and destination in bits 31:16.
  - word 5: link slot number in bits 15:0 and the arrays-per-frame reload in bits 31:16.
  - word 6: frame step, signed, with source in bits 15:0 and destination in bits 31:16.
  - word 7: frame count in bits 15:0.

  A write to the active slot (slot 0) takes effect at the next trigger that finds the channel idle. That trigger's first request is valid in the cycle after the trigger edge.
- R3: With options bit 2 = 0, each trigger produces exactly one request. After that request is accepted, `evt_done` pulses and `req_valid` drops.
- R4: With options bit 2 = 1, one trigger produces all remaining arrays of the current frame back to back. `evt_done` pulses only after the last of them.
- R5: After an array that is not the last of its frame, each address advances by its array step. After the last array of a frame, each address becomes the start of that frame plus its frame step. At the same point, the array count reloads from word 5 and the frame count decrements.
- R6: Options bit 0 (source) and bit 1 (destination) set to 1 keep that address fixed for the whole descriptor.
- R7: While `req_valid` is 1 and `req_ready` is 0, the request outputs hold their values.
- R8: With every completion, `evt_tcc` carries options bits 17:12. `evt_final` is 1 only when the frame count is exhausted. `evt_irq` follows options bit 20 on final completion and bit 21 otherwise. `evt_chain` follows bit 22 on final completion and bit 23 otherwise.
- R9: On final completion, if options bit 3 is 0 and the link is not 0xFFFF, the descriptor in the linked slot becomes the channel's descriptor. The next trigger continues with it.
- R10: After final completion of a static descriptor (bit 3 = 1), or of one whose link is 0xFFFF, triggers produce no request until the active slot is written again.
- R11: A pulse on any of `trig_evt`, `trig_sw` or `trig_chain` starts work.
- R12: `stat_code` becomes 1 at each completion. It becomes 2 when a trigger arrives while a request is outstanding, and the error wins in the same cycle. Such a trigger is otherwise ignored.
- R13: `req_fwid` shows options bits 10:8, the FIFO width code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_evt | input | 1 | Hardware event trigger |
| trig_sw | input | 1 | Manual software trigger |
| trig_chain | input | 1 | Trigger from another channel's completion |
| wr_en | input | 1 | Descriptor store write strobe |
| wr_addr | input | $clog2(NSLOT)+3 | Word address: slot*8 + word |
| wr_data | input | 32 | Descriptor word |
| req_valid | output | 1 | Array request pending |
| req_ready | input | 1 | Data mover accepts the request |
| req_src | output | 32 | Source address of the array |
| req_dst | output | 32 | Destination address of the array |
| req_acnt | output | 16 | Bytes in the array |
| req_fwid | output | 3 | FIFO width code |
| evt_done | output | 1 | Completion pulse |
| evt_final | output | 1 | Completion was the descriptor's last |
| evt_tcc | output | 6 | Completion code |
| evt_irq | output | 1 | Interrupt request with completion |
| evt_chain | output | 1 | Chaining request with completion |
| stat_code | output | 2 | Last status: 0 none, 1 complete, 2 busy trigger |

## Verification
A trigger edge puts the first request on the outputs one cycle later. Each accepting edge updates the next address and, when the trigger's work ends, raises the completion pulse and status at that same edge; the error code from a busy trigger also lands one edge after it. The bench drives every input at the falling edge and compares at the falling edge that follows the relevant rising edge, against a model that steps addresses, counts and link reloads from the requirements.

// File: rtl/dma3d_agen.sv
`timescale 1ns/1ps
module dma3d_agen #(
  parameter int NSLOT    = 8,
  parameter int ACT_SLOT = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trig_evt,
  input  logic                       trig_sw,
  input  logic                       trig_chain,
  input  logic                       wr_en,
  input  logic [$clog2(NSLOT)+2:0]   wr_addr,
  input  logic [31:0]                wr_data,
  output logic                       req_valid,
  input  logic                       req_ready,
  output logic [31:0]                req_src,
  output logic [31:0]                req_dst,
  output logic [15:0]                req_acnt,
  output logic [2:0]                 req_fwid,
  output logic                       evt_done,
  output logic                       evt_final,
  output logic [5:0]                 evt_tcc,
  output logic                       evt_irq,
  output logic                       evt_chain,
  output logic [1:0]                 stat_code
);
  localparam int SW = $clog2(NSLOT);
  localparam int AW = SW + 3;
  localparam logic [SW-1:0] ACT = ACT_SLOT[SW-1:0];
  localparam logic [15:0] NULL_LINK = 16'hFFFF;

  logic [31:0] ram [NSLOT*8];
  always_ff @(posedge clk)
    if (wr_en) ram[wr_addr] <= wr_data;

  logic run, live, pend;
  logic sam, dam, absync, stat_d, ien_f, ien_i, chn_f, chn_i;
  logic [2:0]  fwid;
  logic [5:0]  tcc;
  logic [31:0] src, dst, sfs, dfs;
  logic [15:0] acnt, bcnt, bcntrld, link, ccnt;
  logic [15:0] sbidx, dbidx, scidx, dcidx;

  wire trig     = trig_evt | trig_sw | trig_chain;
  wire hs       = run & req_ready;
  wire last_b   = bcnt == 16'd1;
  wire last_c   = ccnt == 16'd1;
  wire trig_end = hs & (last_b | ~absync);
  wire fin      = hs & last_b & last_c;
  wire reload   = fin & ~stat_d & (link != NULL_LINK);
  wire start_ld = ~run & trig & pend;
  wire do_load  = start_ld | reload;
  wire [SW-1:0] ld_slot = start_ld ? ACT : link[SW-1:0];
  wire act_wr   = wr_en & (wr_addr[AW-1:3] == ACT);

  wire [31:0] sb = {{16{sbidx[15]}}, sbidx};
  wire [31:0] db = {{16{dbidx[15]}}, dbidx};
  wire [31:0] sc = {{16{scidx[15]}}, scidx};
  wire [31:0] dc = {{16{dcidx[15]}}, dcidx};
  wire [31:0] src_nb = sam ? src : src + sb;
  wire [31:0] dst_nb = dam ? dst : dst + db;
  wire [31:0] src_nc = sam ? src : sfs + sc;
  wire [31:0] dst_nc = dam ? dst : dfs + dc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; live <= 1'b0; pend <= 1'b0;
      {sam, dam, absync, stat_d, ien_f, ien_i, chn_f, chn_i} <= '0;
      fwid <= '0; tcc <= '0;
      src <= '0; dst <= '0; sfs <= '0; dfs <= '0;
      acnt <= '0; bcnt <= '0; bcntrld <= '0; link <= NULL_LINK; ccnt <= '0;
      sbidx <= '0; dbidx <= '0; scidx <= '0; dcidx <= '0;
      evt_done <= 1'b0; evt_final <= 1'b0; evt_tcc <= '0;
      evt_irq <= 1'b0; evt_chain <= 1'b0; stat_code <= 2'd0;
    end else begin
      evt_done <= 1'b0; evt_final <= 1'b0; evt_irq <= 1'b0; evt_chain <= 1'b0;

      if (do_load) begin
        sam     <= ram[{ld_slot, 3'd0}][0];
        dam     <= ram[{ld_slot, 3'd0}][1];
        absync  <= ram[{ld_slot, 3'd0}][2];
        stat_d  <= ram[{ld_slot, 3'd0}][3];
        fwid    <= ram[{ld_slot, 3'd0}][10:8];
        tcc     <= ram[{ld_slot, 3'd0}][17:12];
        ien_f   <= ram[{ld_slot, 3'd0}][20];
        ien_i   <= ram[{ld_slot, 3'd0}][21];
        chn_f   <= ram[{ld_slot, 3'd0}][22];
        chn_i   <= ram[{ld_slot, 3'd0}][23];
        src     <= ram[{ld_slot, 3'd1}];
        sfs     <= ram[{ld_slot, 3'd1}];
        acnt    <= ram[{ld_slot, 3'd2}][15:0];
        bcnt    <= ram[{ld_slot, 3'd2}][31:16];
        dst     <= ram[{ld_slot, 3'd3}];
        dfs     <= ram[{ld_slot, 3'd3}];
        sbidx   <= ram[{ld_slot, 3'd4}][15:0];
        dbidx   <= ram[{ld_slot, 3'd4}][31:16];
        link    <= ram[{ld_slot, 3'd5}][15:0];
        bcntrld <= ram[{ld_slot, 3'd5}][31:16];
        scidx   <= ram[{ld_slot, 3'd6}][15:0];
        dcidx   <= ram[{ld_slot, 3'd6}][31:16];
        ccnt    <= ram[{ld_slot, 3'd7}][15:0];
      end else if (hs) begin
        if (last_b) begin
          src <= src_nc; dst <= dst_nc; sfs <= src_nc; dfs <= dst_nc;
          bcnt <= bcntrld; ccnt <= ccnt - 16'd1;
        end else begin
          src <= src_nb; dst <= dst_nb; bcnt <= bcnt - 16'd1;
        end
      end

      if (do_load) pend <= 1'b0;
      if (act_wr)  pend <= 1'b1;

      if (!run && trig && (pend || live)) begin
        run <= 1'b1;
        live <= 1'b1;
      end else if (trig_end) begin
        run <= 1'b0;
        if (fin && !reload) live <= 1'b0;
      end

      if (trig_end) begin
        evt_done  <= 1'b1;
        evt_final <= fin;
        evt_tcc   <= tcc;
        evt_irq   <= fin ? ien_f : ien_i;
        evt_chain <= fin ? chn_f : chn_i;
        stat_code <= 2'd1;
      end
      if (run && trig) stat_code <= 2'd2;
    end
  end

  assign req_valid = run;
  assign req_src   = src;
  assign req_dst   = dst;
  assign req_acnt  = acnt;
  assign req_fwid  = fwid;
endmodule

// File: rtl/dma3d_agen_chk.sv
`timescale 1ns/1ps
module dma3d_agen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        trig_evt,
  input logic        trig_sw,
  input logic        trig_chain,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_src,
  input logic [31:0] req_dst,
  input logic        evt_done,
  input logic        evt_final,
  input logic        evt_irq,
  input logic        evt_chain,
  input logic [1:0]  stat_code
);
  wire trig_any = trig_evt | trig_sw | trig_chain;

  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_src) && $stable(req_dst));

  a_r12_busy_err: assert property (@(posedge clk) disable iff (!rst_n)
    trig_any && req_valid |=> stat_code == 2'd2);

  a_r8_irq_done: assert property (@(posedge clk) disable iff (!rst_n)
    evt_irq |-> evt_done);

  a_r8_chain_done: assert property (@(posedge clk) disable iff (!rst_n)
    evt_chain |-> evt_done);

  a_r8_final_done: assert property (@(posedge clk) disable iff (!rst_n)
    evt_final |-> evt_done);

  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> !req_valid);
endmodule

bind dma3d_agen dma3d_agen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trig_evt(trig_evt), .trig_sw(trig_sw),
  .trig_chain(trig_chain), .req_valid(req_valid), .req_ready(req_ready),
  .req_src(req_src), .req_dst(req_dst), .evt_done(evt_done),
  .evt_final(evt_final), .evt_irq(evt_irq), .evt_chain(evt_chain),
  .stat_code(stat_code)
);

// File: tb/test_dma3d_agen.sv
`timescale 1ns/1ps
module test_dma3d_agen;
  localparam int NSLOT = 8;
  localparam int AW = $clog2(NSLOT) + 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, trig_evt, trig_sw, trig_chain, wr_en, req_ready;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data, req_src, req_dst;
  logic req_valid, evt_done, evt_final, evt_irq, evt_chain;
  logic [15:0] req_acnt;
  logic [2:0] req_fwid;
  logic [5:0] evt_tcc;
  logic [1:0] stat_code;

  dma3d_agen #(.NSLOT(NSLOT), .ACT_SLOT(0)) i_dma3d_agen (
    .clk(clk), .rst_n(rst_n), .trig_evt(trig_evt), .trig_sw(trig_sw),
    .trig_chain(trig_chain), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src), .req_dst(req_dst),
    .req_acnt(req_acnt), .req_fwid(req_fwid), .evt_done(evt_done), .evt_final(evt_final),
    .evt_tcc(evt_tcc), .evt_irq(evt_irq), .evt_chain(evt_chain), .stat_code(stat_code));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic [31:0] mem [NSLOT*8];
  logic [31:0] m_opt, m_src, m_dst, m_sfs, m_dfs, m_bidx, m_lk, m_cidx;
  logic [15:0] m_acnt, m_bcnt, m_ccnt;
  bit m_pend = 0, m_live = 0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic mload(input int s);
    m_opt  = mem[s*8];
    m_src  = mem[s*8+1]; m_sfs = m_src;
    m_acnt = mem[s*8+2][15:0]; m_bcnt = mem[s*8+2][31:16];
    m_dst  = mem[s*8+3]; m_dfs = m_dst;
    m_bidx = mem[s*8+4];
    m_lk   = mem[s*8+5];
    m_cidx = mem[s*8+6];
    m_ccnt = mem[s*8+7][15:0];
  endtask

  task automatic wdesc(input int s, input logic [31:0] w0, w1, w2, w3, w4, w5, w6, w7);
    logic [31:0] w [8];
    w = '{w0, w1, w2, w3, w4, w5, w6, w7};
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(s*8 + k); wr_data = w[k];
      mem[s*8+k] = w[k];
    end
    @(negedge clk);
    wr_en = 1'b0;
    if (s == 0) m_pend = 1;
  endtask

  // one trigger: which 0=event,1=software,2=chain; hold = ready-low cycles per array
  task automatic fire(input int which, input int hold, input bit poke);
    bit lb, lc, tend, fin;
    logic [31:0] ns, nd;
    @(negedge clk);
    case (which)
      0: trig_evt = 1'b1;
      1: trig_sw = 1'b1;
      default: trig_chain = 1'b1;
    endcase
    @(negedge clk);
    trig_evt = 1'b0; trig_sw = 1'b0; trig_chain = 1'b0;
    if (m_pend) begin mload(0); m_pend = 0; m_live = 1; end
    else if (!m_live) begin
      chk("R10", "req_valid after dead trigger", {31'd0, req_valid}, 32'd0);
      return;
    end
    forever begin
      for (int h = 0; h < hold; h++) begin
        chk("R7", "held req_src", req_src, m_src);
        if (poke && h == 0) begin
          trig_sw = 1'b1;
          @(negedge clk);
          trig_sw = 1'b0;
          chk("R12", "stat_code busy", {30'd0, stat_code}, 32'd2);
        end else @(negedge clk);
      end
      chk("R2", "req_valid", {31'd0, req_valid}, 32'd1);
      chk("R5", "req_src", req_src, m_src);
      chk("R5", "req_dst", req_dst, m_dst);
      chk("R2", "req_acnt", {16'd0, req_acnt}, {16'd0, m_acnt});
      chk("R13", "req_fwid", {29'd0, req_fwid}, {29'd0, m_opt[10:8]});
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      lb = (m_bcnt == 16'd1); lc = (m_ccnt == 16'd1);
      tend = lb || !m_opt[2]; fin = lb && lc;
      if (lb) begin
        ns = m_opt[0] ? m_src : m_sfs + sx(m_cidx[15:0]);
        nd = m_opt[1] ? m_dst : m_dfs + sx(m_cidx[31:16]);
        m_sfs = ns; m_dfs = nd; m_bcnt = m_lk[31:16]; m_ccnt = m_ccnt - 16'd1;
      end else begin
        ns = m_opt[0] ? m_src : m_src + sx(m_bidx[15:0]);
        nd = m_opt[1] ? m_dst : m_dst + sx(m_bidx[31:16]);
        m_bcnt = m_bcnt - 16'd1;
      end
      m_src = ns; m_dst = nd;
      if (tend) begin
        chk(m_opt[2] ? "R4" : "R3", "evt_done", {31'd0, evt_done}, 32'd1);
        chk("R3", "req_valid after done", {31'd0, req_valid}, 32'd0);
        chk("R8", "evt_final", {31'd0, evt_final}, {31'd0, fin});
        chk("R8", "evt_tcc", {26'd0, evt_tcc}, {26'd0, m_opt[17:12]});
        chk("R8", "evt_irq", {31'd0, evt_irq}, {31'd0, fin ? m_opt[20] : m_opt[21]});
        chk("R8", "evt_chain", {31'd0, evt_chain}, {31'd0, fin ? m_opt[22] : m_opt[23]});
        chk("R12", "stat_code done", {30'd0, stat_code}, 32'd1);
        if (fin) begin
          if (!m_opt[3] && m_lk[15:0] != 16'hFFFF) begin
            mload(int'(m_lk[$clog2(NSLOT)-1:0])); m_pend = 0;
          end else m_live = 0;
        end
        return;
      end
      chk("R4", "evt_done mid-frame", {31'd0, evt_done}, 32'd0);
    end
  endtask

  task automatic t_reset;
    chk("R1", "req_valid", {31'd0, req_valid}, 32'd0);
    chk("R1", "evt_done", {31'd0, evt_done}, 32'd0);
    chk("R1", "irq/chain/final", {29'd0, evt_irq, evt_chain, evt_final}, 32'd0);
    chk("R1", "stat_code", {30'd0, stat_code}, 32'd0);
  endtask

  // per-array mode, stepping addresses, null link
  task automatic t_array_sync;
    wdesc(0, 32'h0070_5100, 32'h1000_0000, 32'h0003_0004, 32'h2000_0000,
             32'h0020_0010, 32'h0003_FFFF, 32'hFFC0_0100, 32'h0000_0002);
    for (int i = 0; i < 6; i++) fire(i % 3, 0, 0);  // R11 all trigger sources
    fire(0, 0, 0);                                  // R10 null link: ignored
  endtask

  // per-frame mode, fixed source, busy trigger, link to static slot
  task automatic t_frame_sync_link;
    wdesc(3, 32'h0043_F00E, 32'h5000_0000, 32'h0003_0002, 32'h6000_0000,
             32'h0000_FFFC, 32'h0003_0000, 32'h0000_0000, 32'h0000_0001);
    wdesc(0, 32'h0090_9205, 32'h3000_0000, 32'h0002_0008, 32'h4000_0000,
             32'h0008_0005, 32'h0002_0003, 32'h0100_0007, 32'h0000_0002);
    fire(0, 2, 1);   // R12 busy trigger ignored, R7 hold
    fire(1, 0, 0);   // final, R9 reload from slot 3
    fire(2, 1, 0);   // R9 linked descriptor, R6 fixed destination
    fire(0, 0, 0);   // R10 static: ignored
  endtask

  initial begin
    rst_n = 1'b0; trig_evt = 0; trig_sw = 0; trig_chain = 0;
    wr_en = 0; wr_addr = '0; wr_data = '0; req_ready = 0;
    for (int i = 0; i < NSLOT*8; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_array_sync;
    t_frame_sync_link;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule